// File: doc/BRIEF.md
# Board Interrupt Collector with Periodic Timer

This block gathers every interrupt request on a motion-control board into one active-low, level-sensitive host line. Each motion axis offers three active-low level requests (stop, ramp-down and external start). Each request stays asserted for as long as its cause holds, so software silences one only by clearing its enable. The enables arrive inside command words, not through a mask register. A start/stop command carries the stop and external-start enables. A register-select command carries the ramp-down enable.

Beside the axes, the block has a down-counting periodic timer and a set of digital inputs. The timer has a preset register, a latch strobe and a gate. The digital inputs are synchronized and then fire once per edge of a chosen polarity. A control register holds a master enable and one enable per source group. A status register records pending groups. Software clears the status register by writing ones. A status bit sets again on every cycle while its source is still pending.

The timer runs a small state machine with three states. TM_EMPTY means no period has been latched yet. TM_HOLD means a period is loaded and the gate is closed. TM_COUNT means it is counting. The transitions are: latch (EMPTY to HOLD, or straight to COUNT if the gate is open), gate-open (HOLD to COUNT), and gate-close (COUNT to HOLD).

Top module: `irq_collector`

## Requirements
- R1: After reset, `sts` is 0, `irq_n` is 1 and every axis enable is clear, so `axis_pend` stays 0 even when every request input is low.
- R2: `axis_pend[a]` is 1 in any cycle where at least one of axis a's requests is low and that request's enable is set. A command with `cmd_valid`=1 and `cmd_regsel`=0 writes the stop enable from `cmd_ie_a` and the external-start enable from `cmd_ie_b`. A command with `cmd_regsel`=1 writes the ramp-down enable from `cmd_ie_a`. The new enables act from the clock edge that takes the command.
- R3: A register-select command leaves that axis's stop and external-start enables unchanged. A start/stop command leaves its ramp-down enable unchanged.
- R4: Status bit 0 (motion) sets on any edge where some `axis_pend` bit is 1 and control bit 1 is set. It is not cleared by observation. A clear issued while the source is still pending leaves the bit set.
- R5: A clear (`sts_clr`=1) zeroes exactly the status bits whose `sts_clr_mask` bit is 1 and leaves every other bit unchanged.
- R6: `irq_n` is 0 exactly when control bit 0 (master) is 1 and some status bit is 1. It follows `sts` and the control register with no added delay.
- R7: `tmr_preset_we` only stores a preset; the period changes only on `tmr_latch`. With the gate open at the latch edge and preset R, status bit 1 (timer) first sets R+1 edges after the latch edge. It then sets every R+1 edges, whether or not software has cleared it.
- R8: While `tmr_gate` is 0 the count holds and no timer event occurs. After the gate reopens, one edge passes before counting resumes from the held value, with no reload.
- R9: A latch with the gate closed loads the period without counting. With preset R, the first event comes R+2 edges after the gate opens.
- R10: Each `din[i]` passes through two synchronizing flops. With `din_rise[i]`=1 a rising edge sets status bit 2+i on the third clock edge after the change, and a falling edge has no effect. With `din_rise[i]`=0 the roles of the two edges swap.
- R11: A source whose group enable is 0 sets no status bit. The group enables are control bit 1 for motion, bit 2 for the timer and bit 3+i for digital input i.
- R12: With the master bit 0, status bits still set but `irq_n` stays 1. Setting the master bit then drives `irq_n` low from that write's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ax_stop_n | input | NA | Stop request per axis, active low |
| ax_rdn_n | input | NA | Ramp-down request per axis, active low |
| ax_xst_n | input | NA | External-start request per axis, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_regsel | input | 1 | 1: register-select command, 0: start/stop command |
| cmd_axis | input | AXW | Axis addressed by the command |
| cmd_ie_a | input | 1 | Stop enable (start/stop) or ramp-down enable (register-select) |
| cmd_ie_b | input | 1 | External-start enable (start/stop only) |
| axis_pend | output | NA | Per-axis summary of enabled pending requests |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 3+ND | Control value: master, motion, timer, inputs |
| sts_clr | input | 1 | Status clear strobe |
| sts_clr_mask | input | 2+ND | Ones select the status bits to clear |
| sts | output | 2+ND | Status: motion, timer, one bit per input |
| tmr_preset_we | input | 1 | Preset write strobe |
| tmr_preset | input | TW | Preset value |
| tmr_latch | input | 1 | Copies the preset into the period and counter |
| tmr_gate | input | 1 | Count gate, 1 = counting allowed |
| din | input | ND | Digital inputs, asynchronous |
| din_rise | input | ND | Edge choice per input, 1 = rising |
| irq_n | output | 1 | Host interrupt line, active low |

## Verification
Each result has its own latency. `axis_pend` reacts combinationally to the request inputs, and one edge after a command. The motion status bit follows one edge after `axis_pend`. A timer event shows in `sts` R+1 edges after a latch with the gate open, or R+2 edges after a gate opening. A digital-input edge shows on the third edge after the pin changes, and `irq_n` moves together with `sts`. Every task drives its inputs one time unit after a rising edge. It then advances a counted number of edges and samples at the same offset. It checks the edge just before each expected change as well as the edge of the change, so an early or late result fails.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        TM_EMPTY = 2'd0,
        TM_HOLD  = 2'd1,
        TM_COUNT = 2'd2
    } tmr_state_e;

    typedef struct packed {
        logic stop;
        logic rdn;
        logic xst;
    } axis_ie_t;

    localparam int STS_MOT  = 0;
    localparam int STS_TMR  = 1;
    localparam int STS_DIN0 = 2;

    localparam int CTL_MASTER = 0;
    localparam int CTL_MOT    = 1;
    localparam int CTL_TMR    = 2;
    localparam int CTL_DIN0   = 3;

endpackage

// File: rtl/irqc_axis_gate.sv
module irqc_axis_gate
    import irqc_pkg::*;
#(
    parameter int AXW     = 2,
    parameter int AXIS_ID = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic           cmd_regsel,
    input  logic [AXW-1:0] cmd_axis,
    input  logic           cmd_ie_a,
    input  logic           cmd_ie_b,
    input  logic           req_stop_n,
    input  logic           req_rdn_n,
    input  logic           req_xst_n,
    output logic           pend
);

    axis_ie_t ie_q;
    logic     hit;

    assign hit = cmd_valid && (cmd_axis == AXW'(AXIS_ID));

    // Enables live only inside the command words that carry them.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q <= '0;
        end else if (hit) begin
            if (cmd_regsel) begin
                ie_q.rdn <= cmd_ie_a;
            end else begin
                ie_q.stop <= cmd_ie_a;
                ie_q.xst  <= cmd_ie_b;
            end
        end
    end

    assign pend = (ie_q.stop & ~req_stop_n)
                | (ie_q.rdn  & ~req_rdn_n)
                | (ie_q.xst  & ~req_xst_n);

endmodule

// File: rtl/irqc_timer.sv
module irqc_timer
    import irqc_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          preset_we,
    input  logic [TW-1:0] preset_d,
    input  logic          latch,
    input  logic          gate,
    output logic          fire
);

    tmr_state_e    st_q, st_d;
    logic [TW-1:0] preset_q;
    logic [TW-1:0] reload_q;
    logic [TW-1:0] cnt_q;
    logic          step;

    // Next-state decision.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TM_EMPTY: if (latch) st_d = gate ? TM_COUNT : TM_HOLD;
            TM_HOLD:  if (gate)  st_d = TM_COUNT;
            TM_COUNT: if (!gate) st_d = TM_HOLD;
            default:  st_d = TM_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TM_EMPTY;
        else        st_q <= st_d;
    end

    // Outputs of the state machine.
    always_comb begin
        step = (st_q == TM_COUNT) && gate;
        fire = step && !latch && (cnt_q == '0);
    end

    // Preset, period and counter datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preset_q <= '0;
            reload_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (preset_we) preset_q <= preset_d;
            if (latch) begin
                reload_q <= preset_q;
                cnt_q    <= preset_q;
            end else if (step) begin
                cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/irqc_din_edge.sv
module irqc_din_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    output logic pulse
);

    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= pin;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign pulse = rise_sel ? (s2_q & ~s3_q) : (~s2_q & s3_q);

endmodule

// File: rtl/irq_collector.sv
module irq_collector
    import irqc_pkg::*;
#(
    parameter int NA = 4,
    parameter int ND = 4,
    parameter int TW = 16,
    localparam int AXW   = (NA > 1) ? $clog2(NA) : 1,
    localparam int CTL_W = 3 + ND,
    localparam int STS_W = 2 + ND
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NA-1:0]    ax_stop_n,
    input  logic [NA-1:0]    ax_rdn_n,
    input  logic [NA-1:0]    ax_xst_n,
    input  logic             cmd_valid,
    input  logic             cmd_regsel,
    input  logic [AXW-1:0]   cmd_axis,
    input  logic             cmd_ie_a,
    input  logic             cmd_ie_b,
    output logic [NA-1:0]    axis_pend,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             sts_clr,
    input  logic [STS_W-1:0] sts_clr_mask,
    output logic [STS_W-1:0] sts,
    input  logic             tmr_preset_we,
    input  logic [TW-1:0]    tmr_preset,
    input  logic             tmr_latch,
    input  logic             tmr_gate,
    input  logic [ND-1:0]    din,
    input  logic [ND-1:0]    din_rise,
    output logic             irq_n
);

    logic [CTL_W-1:0] ctl_q;
    logic [STS_W-1:0] sts_q;
    logic [STS_W-1:0] set_vec;
    logic [STS_W-1:0] clr_vec;
    logic [ND-1:0]    din_pulse;
    logic             tmr_fire;

    for (genvar a = 0; a < NA; a++) begin : g_axis
        irqc_axis_gate #(
            .AXW     (AXW),
            .AXIS_ID (a)
        ) i_axis (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmd_valid  (cmd_valid),
            .cmd_regsel (cmd_regsel),
            .cmd_axis   (cmd_axis),
            .cmd_ie_a   (cmd_ie_a),
            .cmd_ie_b   (cmd_ie_b),
            .req_stop_n (ax_stop_n[a]),
            .req_rdn_n  (ax_rdn_n[a]),
            .req_xst_n  (ax_xst_n[a]),
            .pend       (axis_pend[a])
        );
    end

    irqc_timer #(
        .TW (TW)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .preset_we (tmr_preset_we),
        .preset_d  (tmr_preset),
        .latch     (tmr_latch),
        .gate      (tmr_gate),
        .fire      (tmr_fire)
    );

    for (genvar i = 0; i < ND; i++) begin : g_din
        irqc_din_edge i_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (din[i]),
            .rise_sel (din_rise[i]),
            .pulse    (din_pulse[i])
        );
        assign set_vec[STS_DIN0+i] = din_pulse[i] & ctl_q[CTL_DIN0+i];
    end

    assign set_vec[STS_MOT] = (|axis_pend) & ctl_q[CTL_MOT];
    assign set_vec[STS_TMR] = tmr_fire & ctl_q[CTL_TMR];
    assign clr_vec          = sts_clr ? sts_clr_mask : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            sts_q <= '0;
        end else begin
            if (ctl_we) ctl_q <= ctl_wdata;
            sts_q <= (sts_q & ~clr_vec) | set_vec;
        end
    end

    assign sts   = sts_q;
    assign irq_n = ~(ctl_q[CTL_MASTER] & (|sts_q));

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
#(
    parameter int NA = 4,
    parameter int ND = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NA-1:0]   axis_pend,
    input logic [3+ND-1:0] ctl_q,
    input logic            ctl_we,
    input logic [3+ND-1:0] ctl_wdata,
    input logic [2+ND-1:0] sts,
    input logic            sts_clr,
    input logic [2+ND-1:0] sts_clr_mask,
    input logic            tmr_gate,
    input logic            irq_n
);

    // R4
    motion_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|axis_pend) && ctl_q[CTL_MOT]) |=> sts[STS_MOT]);

    // R5
    timer_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts[STS_TMR] && !(sts_clr && sts_clr_mask[STS_TMR])) |=> sts[STS_TMR]);

    // R8
    gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_gate && !sts[STS_TMR]) |=> !sts[STS_TMR]);

    // R11
    din_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[STS_DIN0]) |-> $past(ctl_q[CTL_DIN0]));

    // R11
    timer_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[STS_TMR]) |-> $past(ctl_q[CTL_TMR]));

    // R12
    master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q[CTL_MASTER] && !(ctl_we && ctl_wdata[CTL_MASTER])) |=> irq_n);

endmodule

bind irq_collector irqc_chk #(
    .NA (NA),
    .ND (ND)
) u_irqc_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .axis_pend    (axis_pend),
    .ctl_q        (ctl_q),
    .ctl_we       (ctl_we),
    .ctl_wdata    (ctl_wdata),
    .sts          (sts),
    .sts_clr      (sts_clr),
    .sts_clr_mask (sts_clr_mask),
    .tmr_gate     (tmr_gate),
    .irq_n        (irq_n)
);

// File: tb/test_irq_collector.sv
module test_irq_collector;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] ax_stop_n, ax_rdn_n, ax_xst_n;
    logic       cmd_valid, cmd_regsel, cmd_ie_a, cmd_ie_b;
    logic [1:0] cmd_axis;
    logic [3:0] axis_pend;
    logic       ctl_we;
    logic [6:0] ctl_wdata;
    logic       sts_clr;
    logic [5:0] sts_clr_mask;
    logic [5:0] sts;
    logic       tmr_preset_we;
    logic [15:0] tmr_preset;
    logic       tmr_latch, tmr_gate;
    logic [3:0] din, din_rise;
    logic       irq_n;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    irq_collector i_irq_collector (
        .clk(clk), .rst_n(rst_n),
        .ax_stop_n(ax_stop_n), .ax_rdn_n(ax_rdn_n), .ax_xst_n(ax_xst_n),
        .cmd_valid(cmd_valid), .cmd_regsel(cmd_regsel), .cmd_axis(cmd_axis),
        .cmd_ie_a(cmd_ie_a), .cmd_ie_b(cmd_ie_b), .axis_pend(axis_pend),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .sts_clr(sts_clr), .sts_clr_mask(sts_clr_mask), .sts(sts),
        .tmr_preset_we(tmr_preset_we), .tmr_preset(tmr_preset),
        .tmr_latch(tmr_latch), .tmr_gate(tmr_gate),
        .din(din), .din_rise(din_rise), .irq_n(irq_n)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [6:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        step(1);
        ctl_we = 1'b0;
    endtask

    task automatic cmd(input logic rs, input logic [1:0] ax, input logic a, input logic b);
        cmd_valid = 1'b1; cmd_regsel = rs; cmd_axis = ax; cmd_ie_a = a; cmd_ie_b = b;
        step(1);
        cmd_valid = 1'b0;
    endtask

    task automatic clr(input logic [5:0] m);
        sts_clr = 1'b1; sts_clr_mask = m;
        step(1);
        sts_clr = 1'b0;
    endtask

    task automatic t_reset;
        ax_stop_n = '0; ax_rdn_n = '0; ax_xst_n = '0;
        step(2);
        chk("R1 pend in reset", axis_pend, 4'h0);
        rst_n = 1'b1;
        step(3);
        chk("R1 sts", sts, 6'h0);
        chk("R1 irq_n", irq_n, 1'b1);
        chk("R1 pend", axis_pend, 4'h0);
        ax_stop_n = '1; ax_rdn_n = '1; ax_xst_n = '1;
        step(1);
    endtask

    task automatic t_motion;
        wr_ctl(7'h03);
        ax_stop_n[1] = 1'b0;
        #1 chk("R2 stop disabled", axis_pend, 4'h0);
        cmd(1'b0, 2'd1, 1'b1, 1'b0);
        chk("R2 stop enabled", axis_pend, 4'h2);
        step(1);
        chk("R4 motion sts", sts, 6'h01);
        chk("R6 irq_n low", irq_n, 1'b0);
        cmd(1'b1, 2'd1, 1'b0, 1'b0);
        chk("R3 regsel keeps stop", axis_pend, 4'h2);
        step(3);
        chk("R4 no clear on read", sts, 6'h01);
        clr(6'h01);
        chk("R4 clear while pending", sts, 6'h01);
        cmd(1'b0, 2'd1, 1'b0, 1'b0);
        chk("R2 stop disabled again", axis_pend, 4'h0);
        ax_stop_n[1] = 1'b1;
        clr(6'h01);
        chk("R5 cleared", sts, 6'h00);
        chk("R6 irq_n high", irq_n, 1'b1);
        ax_rdn_n[2] = 1'b0;
        cmd(1'b1, 2'd2, 1'b1, 1'b0);
        chk("R2 rampdown enabled", axis_pend, 4'h4);
        cmd(1'b0, 2'd2, 1'b0, 1'b0);
        chk("R3 startstop keeps rdn", axis_pend, 4'h4);
        cmd(1'b1, 2'd2, 1'b0, 1'b0);
        chk("R2 rampdown disabled", axis_pend, 4'h0);
        ax_rdn_n[2] = 1'b1;
        ax_xst_n[3] = 1'b0;
        cmd(1'b0, 2'd3, 1'b0, 1'b1);
        chk("R2 extstart enabled", axis_pend, 4'h8);
        cmd(1'b0, 2'd3, 1'b0, 1'b0);
        chk("R2 extstart disabled", axis_pend, 4'h0);
        ax_xst_n[3] = 1'b1;
        clr(6'h3f);
        chk("R5 all clear", sts, 6'h00);
    endtask

    task automatic t_group_master;
        wr_ctl(7'h01);
        ax_stop_n[0] = 1'b0;
        cmd(1'b0, 2'd0, 1'b1, 1'b0);
        step(3);
        chk("R11 motion group off", sts, 6'h00);
        chk("R11 irq_n high", irq_n, 1'b1);
        wr_ctl(7'h02);
        step(1);
        chk("R12 sts sets with master off", sts, 6'h01);
        chk("R12 irq_n held high", irq_n, 1'b1);
        wr_ctl(7'h03);
        chk("R12 master on", irq_n, 1'b0);
        cmd(1'b0, 2'd0, 1'b0, 1'b0);
        ax_stop_n[0] = 1'b1;
        clr(6'h3f);
        chk("R6 released", irq_n, 1'b1);
    endtask

    task automatic t_din;
        wr_ctl(7'h09);
        din[0] = 1'b1;
        step(2);
        chk("R10 rise not yet", sts, 6'h00);
        step(1);
        chk("R10 rise third edge", sts, 6'h04);
        chk("R6 din irq", irq_n, 1'b0);
        clr(6'h04);
        din[0] = 1'b0;
        step(4);
        chk("R10 fall ignored", sts, 6'h00);
        din_rise[0] = 1'b0;
        step(2);
        din[0] = 1'b1;
        step(4);
        chk("R10 rise ignored in fall mode", sts, 6'h00);
        din[0] = 1'b0;
        step(2);
        chk("R10 fall not yet", sts, 6'h00);
        step(1);
        chk("R10 fall third edge", sts, 6'h04);
        clr(6'h04);
        din_rise[0] = 1'b1;
        wr_ctl(7'h01);
        din[1] = 1'b1;
        step(4);
        chk("R11 din group off", sts, 6'h00);
        din[1] = 1'b0;
        step(4);
    endtask

    task automatic t_w1c;
        wr_ctl(7'h0b);
        ax_stop_n[0] = 1'b0;
        cmd(1'b0, 2'd0, 1'b1, 1'b0);
        din[0] = 1'b1;
        step(3);
        chk("R5 two bits set", sts, 6'h05);
        cmd(1'b0, 2'd0, 1'b0, 1'b0);
        ax_stop_n[0] = 1'b1;
        clr(6'h01);
        chk("R5 masked clear", sts, 6'h04);
        chk("R6 still low", irq_n, 1'b0);
        clr(6'h04);
        chk("R5 rest cleared", sts, 6'h00);
        chk("R6 high again", irq_n, 1'b1);
        din[0] = 1'b0;
        step(4);
        clr(6'h3f);
    endtask

    task automatic t_timer;
        wr_ctl(7'h05);
        tmr_preset_we = 1'b1; tmr_preset = 16'd5;
        step(1);
        tmr_preset_we = 1'b0;
        tmr_gate = 1'b1;
        tmr_latch = 1'b1;
        step(1);
        tmr_latch = 1'b0;
        step(5);
        chk("R7 first event not yet", sts, 6'h00);
        step(1);
        chk("R7 first event", sts, 6'h02);
        chk("R6 timer irq", irq_n, 1'b0);
        clr(6'h02);
        chk("R7 cleared", sts, 6'h00);
        step(4);
        chk("R7 reload not yet", sts, 6'h00);
        step(1);
        chk("R7 auto reload", sts, 6'h02);
        clr(6'h02);
        tmr_preset_we = 1'b1; tmr_preset = 16'd9;
        step(1);
        tmr_preset_we = 1'b0;
        step(3);
        chk("R7 preset alone no effect early", sts, 6'h00);
        step(1);
        chk("R7 period unchanged", sts, 6'h02);
        tmr_gate = 1'b0;
        clr(6'h02);
        tmr_latch = 1'b1;
        step(1);
        tmr_latch = 1'b0;
        step(12);
        chk("R9 latch with gate closed", sts, 6'h00);
        tmr_gate = 1'b1;
        step(10);
        chk("R9 not yet", sts, 6'h00);
        step(1);
        chk("R9 first event after gate", sts, 6'h02);
        clr(6'h02);
        step(1);
        tmr_gate = 1'b0;
        step(8);
        chk("R8 gate closed holds", sts, 6'h00);
        tmr_gate = 1'b1;
        step(8);
        chk("R8 resume not yet", sts, 6'h00);
        step(1);
        chk("R8 resume held count", sts, 6'h02);
        tmr_gate = 1'b0;
        clr(6'h02);
        wr_ctl(7'h01);
        tmr_gate = 1'b1;
        step(25);
        chk("R11 timer group off", sts, 6'h00);
        tmr_gate = 1'b0;
        step(1);
    endtask

    initial begin
        rst_n = 1'b0;
        cmd_valid = 1'b0; cmd_regsel = 1'b0; cmd_axis = '0; cmd_ie_a = 1'b0; cmd_ie_b = 1'b0;
        ctl_we = 1'b0; ctl_wdata = '0; sts_clr = 1'b0; sts_clr_mask = '0;
        tmr_preset_we = 1'b0; tmr_preset = '0; tmr_latch = 1'b0; tmr_gate = 1'b0;
        din = '0; din_rise = '1;
        ax_stop_n = '1; ax_rdn_n = '1; ax_xst_n = '1;
        #1;
        t_reset();
        t_motion();
        t_group_master();
        t_din();
        t_w1c();
        t_timer();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule